// File: doc/BRIEF.md
# Indexed Scatter/Gather Access Sequencer

This block breaks one vector indexed-store (scatter) or indexed-load (gather) request into single-element memory accesses. For each element, the address is a scalar base plus that element's entry in an index vector. The block sends the accesses one at a time through a simple memory port that uses a ready handshake. Elements whose predicate bit is clear are skipped and cause no memory traffic.

A request is accepted on `start` while the block is idle. For a scatter, each active element writes its data word to its address. For a gather, each active element reads its address, and the word that returns one cycle after acceptance is placed in the matching slot of the result vector. When every access has completed, `done` pulses for one cycle.

Top module: `vec_indirect_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are low, `mem_addr` is 0 and `result` is all zeros.
- R2: The address of element i is `base + idx_vec[i*16 +: 16]` modulo 2^16. Element i of any packed vector occupies bits `[i*16 +: 16]`.
- R3: When `is_store` is 1 the request is a scatter: each access drives `mem_we` with `mem_wdata = data_vec[i*16 +: 16]`. When `is_store` is 0 it is a gather and each access drives `mem_re`. `mem_we` and `mem_re` are never high together.
- R4: Active elements are issued in ascending index order. At most one element is accepted per cycle, on a cycle where a request and `mem_ready` are both high.
- R5: An element whose `mask` bit is 0 causes no access. Its slot in a gather result reads 0.
- R6: While a request is not accepted, it stays asserted with the same address on the next cycle.
- R7: For a gather, result slot i equals the `mem_rdata` value present in the cycle after element i's read was accepted.
- R8: `busy` rises in the cycle after a start is accepted. It falls in the same cycle that `done` pulses, and `done` is high for exactly one cycle.
- R9: A `start` received while `busy` is high is ignored: it does not change the accesses or the result of the request in progress.
- R10: With `mem_ready` held high and k active elements, `done` rises k+1 clock edges after the start edge for a scatter. For a gather it rises k+2 edges after the start edge, or 1 edge after when k is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| is_store | input | 1 | 1 = scatter (store), 0 = gather (load) |
| base | input | 16 | Scalar base address |
| idx_vec | input | 64 | Four packed 16-bit indices |
| data_vec | input | 64 | Four packed 16-bit store words |
| mask | input | 4 | Per-element enable |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Gather result vector |
| mem_addr | output | 16 | Element address |
| mem_wdata | output | 16 | Element store data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 16 | Read data, one cycle after acceptance |

## Verification
The checker watches every cycle for the port rules: read and write requests never assert together, a request appears only while busy and stays held with a stable address until ready, busy follows an accepted start, and done lasts one cycle with busy already low. Only the bench scenarios can confirm that the addresses, order and store data match the predicate and index arithmetic, that gathered words land in the right slots, and that a start sent mid-request is ignored. It sweeps every mask under both operations and several ready patterns, and the latency figures are checked against a memory that is always ready.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic { OP_GATHER = 1'b0, OP_SCATTER = 1'b1 } vis_op_e;

  function automatic logic [15:0] elem_addr16(input logic [15:0] b, input logic [15:0] off);
    elem_addr16 = b + off;
  endfunction
endpackage

// File: rtl/vis_pick.sv
module vis_pick #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] sel,
  output logic [N-1:0]  sel_oh
);
  always_comb begin
    found  = 1'b0;
    sel    = '0;
    sel_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found  = 1'b1;
        sel    = IW'(i);
        sel_oh = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/vis_addr.sv
module vis_addr #(
  parameter int N  = 4,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [AW-1:0]   base,
  input  logic [N*AW-1:0] idx_vec,
  input  logic [IW-1:0]   sel,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] off;
  assign off  = idx_vec[sel*AW +: AW];
  assign addr = base + off;
endmodule

// File: rtl/vis_gather_buf.sv
module vis_gather_buf #(
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cap,
  input  logic [IW-1:0]   cap_idx,
  input  logic [DW-1:0]   rdata,
  output logic [N*DW-1:0] result
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 result[g*DW +: DW] <= '0;
      else if (clr)                               result[g*DW +: DW] <= '0;
      else if (cap && (cap_idx == IW'(g)))        result[g*DW +: DW] <= rdata;
    end
  end
endmodule

// File: rtl/vec_indirect_seq.sv
module vec_indirect_seq
  import vis_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_store,
  input  logic [AW-1:0]   base,
  input  logic [N*AW-1:0] idx_vec,
  input  logic [N*DW-1:0] data_vec,
  input  logic [N-1:0]    mask,
  output logic            busy,
  output logic            done,
  output logic [N*DW-1:0] result,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int IW = $clog2(N);

  logic            busy_q, done_q, rd_vld_q;
  vis_op_e         op_q;
  logic [N-1:0]    pend_q;
  logic [AW-1:0]   base_q;
  logic [N*AW-1:0] idx_q;
  logic [N*DW-1:0] data_q;
  logic [IW-1:0]   rd_idx_q;

  logic            found;
  logic [IW-1:0]   cur;
  logic [N-1:0]    cur_oh;
  logic [AW-1:0]   cur_addr;

  // named internal events
  logic start_acc, issue, accept, finish, rd_fire;
  assign start_acc = start && !busy_q;
  assign issue     = busy_q && found;
  assign accept    = issue && mem_ready;
  assign finish    = busy_q && !found && !rd_vld_q;
  assign rd_fire   = rd_vld_q;

  vis_pick #(.N(N)) u_pick (
    .pend(pend_q), .found(found), .sel(cur), .sel_oh(cur_oh)
  );

  vis_addr #(.N(N), .AW(AW)) u_addr (
    .base(base_q), .idx_vec(idx_q), .sel(cur), .addr(cur_addr)
  );

  vis_gather_buf #(.N(N), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .cap(rd_fire),
    .cap_idx(rd_idx_q), .rdata(mem_rdata), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rd_vld_q <= 1'b0;
      rd_idx_q <= '0;
      op_q     <= OP_GATHER;
      pend_q   <= '0;
      base_q   <= '0;
      idx_q    <= '0;
      data_q   <= '0;
    end else begin
      done_q   <= finish;
      rd_vld_q <= accept && (op_q == OP_GATHER);
      if (accept) rd_idx_q <= cur;
      if (start_acc) begin
        busy_q <= 1'b1;
        op_q   <= is_store ? OP_SCATTER : OP_GATHER;
        pend_q <= mask;
        base_q <= base;
        idx_q  <= idx_vec;
        data_q <= data_vec;
      end else if (busy_q) begin
        if (accept) pend_q <= pend_q & ~cur_oh;
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_addr  = issue ? cur_addr : '0;
  assign mem_we    = issue && (op_q == OP_SCATTER);
  assign mem_re    = issue && (op_q == OP_GATHER);
  assign mem_wdata = mem_we ? data_q[cur*DW +: DW] : '0;
endmodule

// File: rtl/vis_chk.sv
module vis_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic          mem_re,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr
);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R4
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && !mem_ready) |=> ((mem_we || mem_re) && $stable(mem_addr)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind vec_indirect_seq vis_chk #(.AW(AW)) u_vis_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_re(mem_re), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/vec_indirect_seq_test.sv
module vec_indirect_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_store = 1'b0;
  logic [15:0] base = '0;
  logic [63:0] idx_vec = '0, data_vec = '0;
  logic [3:0]  mask = '0;
  logic        busy, done, mem_we, mem_re;
  logic        mem_ready = 1'b0;
  logic [63:0] result;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vec_indirect_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .base(base),
    .idx_vec(idx_vec), .data_vec(data_vec), .mask(mask), .busy(busy), .done(done),
    .result(result), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mfun(input logic [15:0] a);
    mfun = {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  // memory model
  int          rmode = 0;
  logic [7:0]  lfsr = 8'h5B;
  logic        pend_rd = 1'b0;
  logic [15:0] pend_a = '0;
  int          log_n = 0;
  logic [15:0] log_a [8];
  logic [15:0] log_d [8];
  logic        log_w [8];
  int          cyc = 0;

  always @(negedge clk) begin
    logic r;
    cyc++;
    if (pend_rd) mem_rdata = mfun(pend_a);
    pend_rd = 1'b0;
    case (rmode)
      0: r = 1'b1;
      1: r = lfsr[0] | lfsr[3];
      default: r = cyc[0];
    endcase
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = r;
    if (r && (mem_we || mem_re)) begin
      if (log_n < 8) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
        log_w[log_n] = mem_we;
      end
      log_n++;
      if (mem_re) begin
        pend_rd = 1'b1;
        pend_a  = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one request; optional disturbing start mid-flight
  task automatic run(input bit st, input logic [15:0] b, input logic [63:0] iv,
                     input logic [63:0] dv, input logic [3:0] m, input bit disturb,
                     output int edges);
    int n;
    @(negedge clk);
    log_n = 0;
    start = 1'b1; is_store = st; base = b; idx_vec = iv; data_vec = dv; mask = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    n = 1;
    while (!done && n < 200) begin
      if (disturb && n == 1 && busy) begin
        start = 1'b1; is_store = ~st; base = ~b; mask = 4'hF; idx_vec = ~iv;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n < 200, "R8 done reached", 64'(n), 64'd0);
    chk(busy === 1'b0, "R8 busy low with done", 64'(busy), 64'd0);
    edges = n - 1;
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic verify(input bit st, input logic [15:0] b, input logic [63:0] iv,
                        input logic [63:0] dv, input logic [3:0] m, input int edges);
    int k = 0;
    int exp_edges;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        logic [15:0] ea;
        ea = b + iv[i*16 +: 16];
        if (k < log_n && k < 8) begin
          chk(log_a[k] === ea, "R2 R4 address order", 64'(log_a[k]), 64'(ea));
          chk(log_w[k] === st, "R3 access kind", 64'(log_w[k]), 64'(st));
          if (st) chk(log_d[k] === dv[i*16 +: 16], "R3 store data", 64'(log_d[k]), 64'(dv[i*16 +: 16]));
        end
        k++;
      end
    end
    chk(log_n == k, "R5 access count", 64'(log_n), 64'(k));
    if (!st) begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] ev;
        ev = m[i] ? mfun(b + iv[i*16 +: 16]) : 16'h0;
        chk(result[i*16 +: 16] === ev, m[i] ? "R7 gather slot" : "R5 masked slot zero",
            64'(result[i*16 +: 16]), 64'(ev));
      end
    end
    if (rmode == 0) begin
      exp_edges = st ? k + 1 : (k == 0 ? 1 : k + 2);
      chk(edges == exp_edges, "R10 latency", 64'(edges), 64'(exp_edges));
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e;
    logic [15:0] b;
    logic [63:0] iv, dv;
    // R1 reset state
    #3;
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 64'd0);
    chk(mem_we === 1'b0 && mem_re === 1'b0 && mem_addr === 16'h0, "R1 mem port",
        {mem_we, mem_re, mem_addr}, 64'd0);
    chk(result === 64'h0, "R1 result", result, 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 wrap case
    rmode = 0;
    run(1'b0, 16'hFFF0, {16'h0003, 16'h8000, 16'h0010, 16'h0020}, 64'h0, 4'hF, 1'b0, e);
    verify(1'b0, 16'hFFF0, {16'h0003, 16'h8000, 16'h0010, 16'h0020}, 64'h0, 4'hF, e);

    // sweep: all masks, both ops, three ready patterns
    for (int md = 0; md < 3; md++) begin
      rmode = md;
      for (int op = 0; op < 2; op++) begin
        for (int m = 0; m < 16; m++) begin
          int s = md * 32 + op * 16 + m;
          b  = 16'(s * 16'h0F35 + 16'hE100);
          iv = {16'(s * 7 + 16'h9000), 16'(s * 131 + 16'h0044), 16'(16'hFFFF - s), 16'(s * 4099)};
          dv = {16'(s ^ 16'hA000), 16'(s ^ 16'h0B00), 16'(s ^ 16'h00C0), 16'(s ^ 16'h000D)};
          run(op[0], b, iv, dv, 4'(m), 1'b0, e);
          verify(op[0], b, iv, dv, 4'(m), e);
        end
      end
    end

    // R9 start while busy ignored (gather then scatter)
    rmode = 2;
    iv = {16'h0400, 16'h0300, 16'h0200, 16'h0100};
    dv = 64'h4444_3333_2222_1111;
    run(1'b0, 16'h1000, iv, dv, 4'b1011, 1'b1, e);
    verify(1'b0, 16'h1000, iv, dv, 4'b1011, e);
    chk(log_n == 3, "R9 no extra accesses", 64'(log_n), 64'd3);
    run(1'b1, 16'h2000, iv, dv, 4'b0110, 1'b1, e);
    verify(1'b1, 16'h2000, iv, dv, 4'b0110, e);
    chk(log_n == 2, "R9 no extra stores", 64'(log_n), 64'd2);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule